// File: doc/BRIEF.md
# Half-Duplex Nine-Bit Serial Transceiver

This block is an asynchronous serial port that moves nine-bit characters over one input pin and one output pin. Transmit and receive share a single bit-timing engine: one shift register, one phase counter and one baud divider. The port is therefore half duplex. A transmit request always wins. If a character is being received when software writes the data register, the reception is dropped and the transmit frame goes out.

Software sees three byte-wide registers on a small synchronous bus. The data register sits at address 0. A write to it starts a frame, and a read of it returns the last received byte. The control register at address 1 holds the rate code, the interrupt enables, the pin enable and the shared ninth data bit. The status register at address 2 holds the transmitter-empty and receive-ready flags. A single interrupt line combines both flag/enable pairs. Each bit lasts eight timing states. The length of a state comes from a fixed table of clock divisors, divided again by the parameter `STATE_DIV_SCALE`.

Top module: `uart9_top`

## Requirements
- R1: After reset, `serial_out` is 1, `irq` is 0, the control register reads 0x00 and the status register reads 0x01 (TXMT set, RXRDY clear).
- R2: Rate codes 0 to 6 in control bits [3:0] use bit divisors 6656, 3328, 1664, 832, 416, 256 and 208. One state lasts max(1, floor(divisor / (8*STATE_DIV_SCALE))) clock cycles. One bit lasts 8 states, and the transmitted start bit stays low for exactly that long.
- R3: A write to address 0 sends, from the next clock edge, one low start bit, then data bits 0 to 7 least significant first, then the ninth bit (control bit 7), then one high stop bit. While the output enable (control bit 6) is 0, `serial_out` stays high.
- R4: A write to address 0 clears TXMT (status bit 0). TXMT is set again once the stop bit ends. `irq` is asserted while TXMT and the transmit enable (control bit 4) are both 1.
- R5: While the engine is idle, a falling edge on `serial_in` starts a reception. The engine skips one bit time, samples nine bits at state 4 of each bit, and waits one bit time for the stop bit. It then loads the low eight bits into the buffer that address 0 reads back.
- R6: When a reception completes, its ninth bit replaces control bit 7, whatever value software wrote there.
- R7: RXRDY (status bit 1) is set when the buffer is loaded and is cleared by a read of address 0. `irq` is asserted while RXRDY and the receive enable (control bit 5) are both 1.
- R8: A data write during a reception abandons that reception. The transmit frame goes out intact, and RXRDY and the receive buffer keep their previous values.
- R9: While the rate code is 7 or above, a data write starts no frame and leaves TXMT at 1, and falling edges on `serial_in` start no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 0 clears RXRDY |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| serial_in | input | 1 | Serial receive line |
| serial_out | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `STATE_DIV_SCALE` = 4. This brings the slowest rate code down to 1664 cycles per bit. All seven rate codes can then be swept, each with a full transmit frame and a full receive frame, within the cycle budget. The fastest code then runs at six cycles per state. This is the tightest margin between the input synchronizer delay and the mid-bit sample point.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    localparam int CNT_W   = 16;
    localparam int FRAME_W = 11;   // start + 9 data + stop
    localparam int WORD_W  = 9;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RXSTART,
        ENG_RXDATA,
        ENG_RXSTOP,
        ENG_TX
    } eng_state_e;

    typedef struct packed {
        eng_state_e         st;
        logic [2:0]         phase;
        logic [3:0]         bitn;
        logic [FRAME_W-1:0] shreg;
    } eng_regs_t;

    typedef struct packed {
        logic       bit9;
        logic       oe;
        logic       rxien;
        logic       txien;
        logic [3:0] sel;
    } ctrl_t;

    function automatic int unsigned bit_divisor(input logic [3:0] sel);
        case (sel)
            4'd0:    return 6656;
            4'd1:    return 3328;
            4'd2:    return 1664;
            4'd3:    return 832;
            4'd4:    return 416;
            4'd5:    return 256;
            4'd6:    return 208;
            default: return 0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] state_period(input logic [3:0] sel, input int scale);
        int unsigned v;
        v = bit_divisor(sel) / (8 * scale);
        if (v < 1) v = 1;
        return v[CNT_W-1:0];
    endfunction

    function automatic logic sel_reserved(input logic [3:0] sel);
        return sel >= 4'd7;
    endfunction

endpackage

// File: rtl/uart9_baud.sv
module uart9_baud
    import uart9_pkg::*;
#(
    parameter int SCALE = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] sel,
    input  logic       restart,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic             wrap;

    assign period = state_period(sel, SCALE);
    assign wrap   = (cnt >= period - 1'b1);
    assign tick   = wrap && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // R2: consecutive state ticks are spaced by the period
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && period > 1) |=> (!tick || period == 1));

endmodule

// File: rtl/uart9_engine.sv
module uart9_engine
    import uart9_pkg::*;
#(
    parameter int SCALE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        sel,
    input  logic              tx_start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_pin,
    output logic              line,
    output logic              tx_done,
    output logic              rx_done,
    output logic [WORD_W-1:0] rx_word
);
    eng_regs_t r;
    logic      rx_meta, rx_sync, rx_last;
    logic      reserved, go_tx, go_rx, restart, tick, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
            rx_last <= 1'b1;
        end else begin
            rx_meta <= rx_pin;
            rx_sync <= rx_meta;
            rx_last <= rx_sync;
        end
    end

    assign reserved = sel_reserved(sel);
    assign fall     = rx_last && !rx_sync;
    assign go_tx    = tx_start && !reserved;
    assign go_rx    = (r.st == ENG_IDLE) && fall && !reserved && !go_tx;
    assign restart  = go_tx || go_rx;

    uart9_baud #(.SCALE(SCALE)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .restart (restart),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r       <= '{st: ENG_IDLE, phase: '0, bitn: '0, shreg: '1};
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
            if (reserved) begin
                r <= '{st: ENG_IDLE, phase: '0, bitn: '0, shreg: '1};
            end else if (go_tx) begin
                r <= '{st: ENG_TX, phase: '0, bitn: '0, shreg: {1'b1, tx_word, 1'b0}};
            end else if (go_rx) begin
                r.st    <= ENG_RXSTART;
                r.phase <= '0;
                r.bitn  <= '0;
            end else if (tick) begin
                r.phase <= r.phase + 1'b1;
                case (r.st)
                    ENG_RXSTART: if (r.phase == 3'd7) r.st <= ENG_RXDATA;
                    ENG_RXDATA: begin
                        if (r.phase == 3'd4)
                            r.shreg[WORD_W-1:0] <= {rx_sync, r.shreg[WORD_W-1:1]};
                        if (r.phase == 3'd7) begin
                            if (r.bitn == 4'(WORD_W - 1)) begin
                                r.st   <= ENG_RXSTOP;
                                r.bitn <= '0;
                            end else begin
                                r.bitn <= r.bitn + 1'b1;
                            end
                        end
                    end
                    ENG_RXSTOP: if (r.phase == 3'd7) begin
                        r.st    <= ENG_IDLE;
                        rx_done <= 1'b1;
                    end
                    ENG_TX: if (r.phase == 3'd7) begin
                        r.shreg <= {1'b1, r.shreg[FRAME_W-1:1]};
                        if (r.bitn == 4'(FRAME_W - 1)) begin
                            r.st    <= ENG_IDLE;
                            tx_done <= 1'b1;
                        end else begin
                            r.bitn <= r.bitn + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign line    = (r.st == ENG_TX) ? r.shreg[0] : 1'b1;
    assign rx_word = r.shreg[WORD_W-1:0];

    // R3: an accepted start drives the start bit low on the next cycle
    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !reserved) |=> (line == 1'b0));

    // R8: a transmit request aborts any reception in progress
    p_abort_rx_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !reserved && (r.st == ENG_RXSTART || r.st == ENG_RXDATA || r.st == ENG_RXSTOP))
        |=> (r.st == ENG_TX && !rx_done));

    // R9: a reserved rate code keeps the engine quiet
    p_reserved_idle_r9: assert property (@(posedge clk) disable iff (rst)
        reserved |=> (line && !tx_done && !rx_done));

    // R5: the two completion pulses never coincide
    p_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(tx_done && rx_done));

endmodule

// File: rtl/uart9_top.sv
module uart9_top
    import uart9_pkg::*;
#(
    parameter int STATE_DIV_SCALE = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       serial_in,
    output logic       serial_out,
    output logic       irq
);
    ctrl_t             ctrl;
    logic [7:0]        rxbuf;
    logic              txmt, rxrdy;
    logic              data_wr, data_rd, ctrl_wr, accept;
    logic              line, tx_done, rx_done;
    logic [WORD_W-1:0] rx_word;

    assign data_wr = bus_wr && (bus_addr == 2'd0);
    assign ctrl_wr = bus_wr && (bus_addr == 2'd1);
    assign data_rd = bus_rd && (bus_addr == 2'd0);
    assign accept  = data_wr && !sel_reserved(ctrl.sel);

    uart9_engine #(.SCALE(STATE_DIV_SCALE)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .sel      (ctrl.sel),
        .tx_start (data_wr),
        .tx_word  ({ctrl.bit9, bus_wdata}),
        .rx_pin   (serial_in),
        .line     (line),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            rxbuf <= '0;
            txmt  <= 1'b1;
            rxrdy <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata);
            if (rx_done) begin
                ctrl.bit9 <= rx_word[WORD_W-1];
                rxbuf     <= rx_word[7:0];
                rxrdy     <= 1'b1;
            end else if (data_rd) begin
                rxrdy <= 1'b0;
            end
            if (accept)       txmt <= 1'b0;
            else if (tx_done) txmt <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            2'd0:    bus_rdata = rxbuf;
            2'd1:    bus_rdata = ctrl;
            2'd2:    bus_rdata = {6'b0, rxrdy, txmt};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign serial_out = ctrl.oe ? line : 1'b1;
    assign irq        = (txmt && ctrl.txien) || (rxrdy && ctrl.rxien);

    // R4: an accepted data write empties the transmitter
    p_txmt_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && ctrl.sel < 4'd7) |=> !txmt);

    // R7: a completed reception raises the ready flag
    p_rxrdy_set_r7: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rxrdy);

    // R7: reading the data register clears the ready flag
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0 && !rx_done) |=> !rxrdy);

    // R9: a reserved code leaves TXMT untouched by data writes
    p_reserved_txmt_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && ctrl.sel >= 4'd7 && txmt) |=> txmt);

endmodule

// File: tb/sim_uart9_top.sv
module sim_uart9_top;
    localparam int SCALE = 4;
    localparam int NVEC  = 7;
    // vector = {rate code, nine-bit word}; every word has bit 0 set
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd0, 9'h1A5}, {4'd1, 9'h0F3}, {4'd2, 9'h101}, {4'd3, 9'h1FF},
        {4'd4, 9'h055}, {4'd5, 9'h0C9}, {4'd6, 9'h133}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       serial_in, serial_out, irq;

    always #10 clk = ~clk;

    uart9_top #(.STATE_DIV_SCALE(SCALE)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .serial_in(serial_in),
        .serial_out(serial_out), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    function automatic int bitlen(input logic [3:0] s);
        int d;
        case (s)
            4'd0: d = 6656;  4'd1: d = 3328;  4'd2: d = 1664;  4'd3: d = 832;
            4'd4: d = 416;   4'd5: d = 256;   4'd6: d = 208;   default: d = 0;
        endcase
        d = d / (8 * SCALE);
        if (d < 1) d = 1;
        return 8 * d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // tasks start and end on a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic see_tx(input int b, input logic [8:0] w, input string req);
        int run = 0;
        while (serial_out === 1'b0 && run < 40000) begin
            run++;
            @(negedge clk);
        end
        chk({req, " R2 start bit length"}, run, b);
        repeat (b / 2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            chk({req, " R3 frame bit"}, int'(serial_out), (k < 9) ? int'(w[k]) : 1);
            repeat (b) @(negedge clk);
        end
    endtask

    task automatic tx_check(input logic [3:0] s, input logic [8:0] w);
        logic [7:0] v;
        wr(2'd1, {w[8], 1'b1, 1'b0, 1'b1, s});
        wr(2'd0, w[7:0]);
        chk("R4 irq low while sending", int'(irq), 0);
        see_tx(bitlen(s), w, "R3");
        rd(2'd2, v);
        chk("R4 TXMT after stop bit", int'(v[0]), 1);
        chk("R4 irq with TXIEN", int'(irq), 1);
    endtask

    task automatic rx_frame(input int b, input logic [8:0] w);
        serial_in = 1'b0;
        repeat (b) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            serial_in = w[k];
            repeat (b) @(negedge clk);
        end
        serial_in = 1'b1;
        repeat (2 * b) @(negedge clk);
    endtask

    task automatic rx_check(input logic [3:0] s, input logic [8:0] w);
        logic [7:0] v;
        wr(2'd1, {~w[8], 1'b0, 1'b1, 1'b0, s});
        rx_frame(bitlen(s), w);
        rd(2'd2, v);
        chk("R7 RXRDY set", int'(v[1]), 1);
        chk("R7 irq with RXIEN", int'(irq), 1);
        rd(2'd1, v);
        chk("R6 ninth bit overwritten", int'(v[7]), int'(w[8]));
        rd(2'd0, v);
        chk("R5 received byte", int'(v), int'(w[7:0]));
        rd(2'd2, v);
        chk("R7 RXRDY cleared by read", int'(v[1]), 0);
        chk("R7 irq drops", int'(irq), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        int lows;
        rst = 1'b1; serial_in = 1'b1;
        bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 serial_out idle", int'(serial_out), 1);
        chk("R1 irq", int'(irq), 0);
        rd(2'd1, v); chk("R1 control", int'(v), 0);
        rd(2'd2, v); chk("R1 status", int'(v), 1);

        // table walk over every rate code
        for (int i = 0; i < NVEC; i++) begin
            tx_check(VEC[i][12:9], VEC[i][8:0]);
            rx_check(VEC[i][12:9], VEC[i][8:0]);
        end

        // R3: output enable off keeps the pin high for a whole frame
        wr(2'd1, {1'b1, 1'b0, 2'b00, 4'd6});
        wr(2'd0, 8'h00);
        lows = 0;
        for (int c = 0; c < 11 * bitlen(4'd6) + 8; c++) begin
            if (serial_out !== 1'b1) lows++;
            @(negedge clk);
        end
        chk("R3 pin high while disabled", lows, 0);
        rd(2'd2, v); chk("R4 TXMT after hidden frame", int'(v[0]), 1);

        // R8: transmit pre-empts a reception
        rx_check(4'd6, 9'h0AA);
        wr(2'd1, {1'b0, 1'b1, 1'b0, 1'b1, 4'd6});
        serial_in = 1'b0;
        repeat (3 * bitlen(4'd6)) @(negedge clk);
        serial_in = 1'b1;
        wr(2'd0, 8'h5B);
        see_tx(bitlen(4'd6), 9'h05B, "R8");
        repeat (2 * bitlen(4'd6)) @(negedge clk);
        rd(2'd2, v); chk("R8 RXRDY unchanged", int'(v[1]), 0);
        rd(2'd0, v); chk("R8 buffer unchanged", int'(v), 8'hAA);

        // R9: reserved rate code
        wr(2'd1, {1'b0, 1'b1, 1'b0, 1'b0, 4'd7});
        wr(2'd0, 8'h00);
        lows = 0;
        for (int c = 0; c < 300; c++) begin
            if (serial_out !== 1'b1) lows++;
            @(negedge clk);
        end
        chk("R9 no frame sent", lows, 0);
        rd(2'd2, v); chk("R9 TXMT stays set", int'(v[0]), 1);
        serial_in = 1'b0;
        repeat (300) @(negedge clk);
        serial_in = 1'b1;
        repeat (600) @(negedge clk);
        rd(2'd2, v); chk("R9 no reception", int'(v[1]), 0);

        summary();
    end
endmodule